// File: doc/BRIEF.md
# Display Controller Register and Interrupt Block

This block is the 32-bit control register file of a display controller. Software reaches it through a single-cycle valid/write/address/data port. It holds the global control word, the panel configuration, the timing and divisor words, the output sizes and the graphics-layer parameters. Toward the pixel pipeline it drives the two output enables and an active copy of every timing, size and layer field.

Software never writes the active copy directly. Each write lands in a shadow register. Setting one of the two per-output go bits in the control word arms a transfer. The next frame-boundary pulse for that output copies the shadow set into the active set, which keeps a frame from being built from half-updated parameters.

Status events from the pipeline collect in a write-one-to-clear interrupt status register. A single level interrupt is the OR of status masked by enable. A write to the system configuration register can reset the whole block from software.

Top module: `dispctl_regs`

## Requirements
- R1: After reset the registers read as follows. Capability (0x14) reads 0x161. Graphics row increment (0x50) and pixel increment (0x54) read 1. System status (0x04) reads 1. Every other register reads 0, including the graphics size at 0x48, which encodes a 1x1 layer. `irq`, `lcd_en`, `dig_en` and every `act_*` output are 0.
- R2: A read (`reg_valid`=1, `reg_write`=0) returns its data on `reg_rdata` with `reg_rvalid`=1 in the following cycle. A read of any offset not listed in these requirements, such as 0x58, returns 0.
- R3: Writes keep only these bits:
  - control (0x10): 0x07FF9FFF
  - horizontal timing (0x28) and vertical timing (0x2C): 0x0FF0FF3F
  - polarity/frequency (0x30): 0x0003FFFF
  - divisor (0x34): 0x00FF00FF
  - background colors (0x18, 0x1C) and transparency colors (0x20, 0x24): 24 bits
  - graphics attributes (0x4C): 11 bits, where bit 0 is the layer enable and bits 4:1 are the pixel format
  - capability (0x14): 0x3FF
  - interrupt enable (0x0C): 16 bits
  - graphics base (0x40) and both increments: all 32 bits
- R4: The LCD size (0x38), digital size (0x3C), graphics size (0x48) and graphics position (0x44) registers hold pixels per line minus one in bits 10:0 and lines minus one in bits 26:16. All other bits are dropped, and reads return the same minus-one encoding.
- R5: Interrupt status (0x08) takes each set bit of `irq_event`. A write to it clears every bit written as 1 and leaves the others. When an event and a clear hit the same bit in the same cycle, the bit stays set.
- R6: `irq` is 1 exactly when status AND enable is non-zero. It reflects each status or enable update from the cycle after that update.
- R7: Control bit 0 drives `lcd_en` and control bit 1 drives `dig_en`, from the cycle after the control write.
- R8: Writing control with bit 5 set arms the LCD go. Bit 5 then reads 1, and a later control write with bit 5 clear does not cancel it. The next `lcd_frame_end` pulse copies these shadow values to the matching `act_*` outputs and clears bit 5:
  - timing words
  - polarity/frequency
  - divisor
  - LCD size
  - graphics base, position, size and attributes
- R9: Writing control with bit 6 set arms the digital go, which reads 1 in bit 6. The next `dig_frame_end` pulse copies the digital size and the graphics fields to the active outputs and clears bit 6.
- R10: An `act_*` output changes only on a transfer that covers it. Shadow writes, and frame pulses with no armed go, leave it unchanged.
- R11: Writing system configuration (0x00) with bit 1 set returns every other register, both go bits, status, `irq` and all active outputs to their reset values in the next cycle. System configuration itself keeps the written value masked by 0x301B.
- R12: Writes to unlisted offsets (such as 0x58) and to system status change no register and no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_valid | input | 1 | Register access this cycle |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | AW | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after the read |
| reg_rvalid | output | 1 | Marks `reg_rdata` valid |
| irq_event | input | IRQ_W | Per-bit status set pulses from the pipeline |
| lcd_frame_end | input | 1 | LCD frame boundary pulse |
| dig_frame_end | input | 1 | Digital output frame boundary pulse |
| irq | output | 1 | Level interrupt |
| lcd_en | output | 1 | LCD output enable |
| dig_en | output | 1 | Digital output enable |
| act_timing_h | output | 32 | Active horizontal timing |
| act_timing_v | output | 32 | Active vertical timing |
| act_pol_freq | output | 32 | Active polarity/frequency word |
| act_divisor | output | 32 | Active divisor word |
| act_lcd_size | output | 32 | Active LCD size, minus-one encoded |
| act_dig_size | output | 32 | Active digital size, minus-one encoded |
| act_gfx_base | output | 32 | Active graphics base address |
| act_gfx_pos | output | 32 | Active graphics position |
| act_gfx_size | output | 32 | Active graphics size, minus-one encoded |
| act_gfx_attr | output | 32 | Active graphics attributes |

## Verification
The hardest cases to reach from the ports are cycle coincidences.

- **Event and clear on one bit.** An event arrives on a status bit in the same clock as a software clear of that bit. The stimulus drives `irq_event` and the clearing write on the same falling edge, then reads the bit back.
- **Go across writes.** An armed go must survive a later control write that drops the bit. It must also ignore the other output's frame pulse. The stimulus arms the go, rewrites control, and pulses the wrong frame input before the right one, checking the active outputs between each step.

// File: rtl/dispctl_pkg.sv
package dispctl_pkg;
  localparam int DW = 32;
  typedef logic [DW-1:0] word_t;

  // register offsets (byte addresses)
  localparam int unsigned OFF_SYSCFG  = 'h00;
  localparam int unsigned OFF_SYSSTAT = 'h04;
  localparam int unsigned OFF_IRQST   = 'h08;
  localparam int unsigned OFF_IRQEN   = 'h0C;
  localparam int unsigned OFF_CTRL    = 'h10;
  localparam int unsigned OFF_CAPS    = 'h14;
  localparam int unsigned OFF_BG0     = 'h18;
  localparam int unsigned OFF_BG1     = 'h1C;
  localparam int unsigned OFF_TR0     = 'h20;
  localparam int unsigned OFF_TR1     = 'h24;
  localparam int unsigned OFF_TIMH    = 'h28;
  localparam int unsigned OFF_TIMV    = 'h2C;
  localparam int unsigned OFF_POL     = 'h30;
  localparam int unsigned OFF_DIV     = 'h34;
  localparam int unsigned OFF_LCDSZ   = 'h38;
  localparam int unsigned OFF_DIGSZ   = 'h3C;
  localparam int unsigned OFF_GBASE   = 'h40;
  localparam int unsigned OFF_GPOS    = 'h44;
  localparam int unsigned OFF_GSIZE   = 'h48;
  localparam int unsigned OFF_GATTR   = 'h4C;
  localparam int unsigned OFF_ROWINC  = 'h50;
  localparam int unsigned OFF_PIXINC  = 'h54;

  // write masks
  localparam word_t M_SYSCFG = 32'h0000_301B;
  localparam word_t M_CTRL   = 32'h07FF_9FFF;
  localparam word_t M_CAPS   = 32'h0000_03FF;
  localparam word_t M_COLOR  = 32'h00FF_FFFF;
  localparam word_t M_TIMING = 32'h0FF0_FF3F;
  localparam word_t M_POL    = 32'h0003_FFFF;
  localparam word_t M_DIV    = 32'h00FF_00FF;
  localparam word_t M_XY     = 32'h07FF_07FF;
  localparam word_t M_ATTR   = 32'h0000_07FF;

  // control bit positions and counts
  localparam int SOFT_RST_BIT = 1;
  localparam int GO_BIT_LO    = 5;   // bit 5 = LCD go, bit 6 = digital go
  localparam int NUM_OUT      = 2;
  localparam word_t GO_BITS   = word_t'(((1 << NUM_OUT) - 1) << GO_BIT_LO);

  // reset values
  localparam word_t RST_CAPS = 32'h0000_0161;
  localparam word_t RST_INC  = 32'h0000_0001;
endpackage

// File: rtl/dispctl_irq.sv
module dispctl_irq #(
  parameter int IRQ_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_we,
  input  logic             clr_we,
  input  logic [IRQ_W-1:0] wr_bits,
  input  logic [IRQ_W-1:0] event_bits,
  output logic [IRQ_W-1:0] status,
  output logic [IRQ_W-1:0] enable,
  output logic             irq
);
  logic [IRQ_W-1:0] status_n, enable_n;

  always_comb begin
    status_n = (status & ~(clr_we ? wr_bits : '0)) | event_bits;
    enable_n = en_we ? wr_bits : enable;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      enable <= '0;
      irq    <= 1'b0;
    end else begin
      status <= status_n;
      enable <= enable_n;
      irq    <= |(status_n & enable_n);
    end
  end

  // R5: clearing all bits with no event leaves status empty
  a_r5_clear_all: assert property (@(posedge clk) disable iff (rst)
    (clr_we && (&wr_bits) && event_bits == '0) |=> status == '0);
  // R5: an event bit is always recorded
  a_r5_event_sets: assert property (@(posedge clk) disable iff (rst)
    (event_bits != '0) |=> ((status & $past(event_bits)) == $past(event_bits)));
  // R6: with nothing enabled and no enable write, no interrupt follows
  a_r6_masked_quiet: assert property (@(posedge clk) disable iff (rst)
    (!en_we && enable == '0) |=> !irq);
endmodule

// File: rtl/dispctl_go_track.sv
module dispctl_go_track (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic frame_end,
  output logic pending,
  output logic xfer
);
  assign xfer = pending & frame_end;

  always_ff @(posedge clk) begin
    if (rst) pending <= 1'b0;
    else     pending <= set | (pending & ~frame_end);
  end

  // R8/R9: a go bit only self-clears at a frame boundary (or reset)
  a_r8_clear_on_frame: assert property (@(posedge clk) disable iff (rst)
    $fell(pending) |-> ($past(frame_end) || $past(rst)));
  // R8: an armed go survives cycles without a frame boundary
  a_r8_hold_armed: assert property (@(posedge clk) disable iff (rst)
    (pending && !frame_end) |=> pending);
endmodule

// File: rtl/dispctl_shadow_bank.sv
module dispctl_shadow_bank #(
  parameter int N = 4,
  parameter int W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic [N-1:0][W-1:0] shadow,
  output logic [N-1:0][W-1:0] active
);
  always_ff @(posedge clk) begin
    if (rst)       active <= '0;
    else if (load) active <= shadow;
  end

  // R10: the active set holds between transfers
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(active));
endmodule

// File: rtl/dispctl_regs.sv
module dispctl_regs #(
  parameter int AW    = 8,
  parameter int IRQ_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_valid,
  input  logic             reg_write,
  input  logic [AW-1:0]    reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             reg_rvalid,
  input  logic [IRQ_W-1:0] irq_event,
  input  logic             lcd_frame_end,
  input  logic             dig_frame_end,
  output logic             irq,
  output logic             lcd_en,
  output logic             dig_en,
  output logic [31:0]      act_timing_h,
  output logic [31:0]      act_timing_v,
  output logic [31:0]      act_pol_freq,
  output logic [31:0]      act_divisor,
  output logic [31:0]      act_lcd_size,
  output logic [31:0]      act_dig_size,
  output logic [31:0]      act_gfx_base,
  output logic [31:0]      act_gfx_pos,
  output logic [31:0]      act_gfx_size,
  output logic [31:0]      act_gfx_attr
);
  import dispctl_pkg::*;

  localparam int LCD_N = 5;
  localparam int GFX_N = 4;

  function automatic logic at(input logic [AW-1:0] a, input int unsigned off);
    return a == AW'(off);
  endfunction

  logic wr_en, rd_en, soft_rst, srst;
  assign wr_en    = reg_valid & reg_write;
  assign rd_en    = reg_valid & ~reg_write;
  assign soft_rst = wr_en && at(reg_addr, OFF_SYSCFG) && reg_wdata[SOFT_RST_BIT];
  assign srst     = rst | soft_rst;

  word_t sys_cfg, ctrl_q, caps;
  word_t bg [2];
  word_t tr [2];
  word_t tim_h, tim_v, pol, div_w, lcd_sz, dig_sz;
  word_t g_base, g_pos, g_size, g_attr, row_inc, pix_inc;

  // system configuration survives its own soft reset (keeps masked value)
  always_ff @(posedge clk) begin
    if (rst) sys_cfg <= '0;
    else if (wr_en && at(reg_addr, OFF_SYSCFG)) sys_cfg <= reg_wdata & M_SYSCFG;
  end

  // shadow / plain registers
  always_ff @(posedge clk) begin
    if (srst) begin
      ctrl_q <= '0;  caps <= RST_CAPS;
      bg[0] <= '0;   bg[1] <= '0;  tr[0] <= '0;  tr[1] <= '0;
      tim_h <= '0;   tim_v <= '0;  pol <= '0;    div_w <= '0;
      lcd_sz <= '0;  dig_sz <= '0;
      g_base <= '0;  g_pos <= '0;  g_size <= '0; g_attr <= '0;
      row_inc <= RST_INC;  pix_inc <= RST_INC;
    end else if (wr_en) begin
      case (reg_addr)
        AW'(OFF_CTRL):   ctrl_q  <= reg_wdata & M_CTRL & ~GO_BITS;
        AW'(OFF_CAPS):   caps    <= reg_wdata & M_CAPS;
        AW'(OFF_BG0):    bg[0]   <= reg_wdata & M_COLOR;
        AW'(OFF_BG1):    bg[1]   <= reg_wdata & M_COLOR;
        AW'(OFF_TR0):    tr[0]   <= reg_wdata & M_COLOR;
        AW'(OFF_TR1):    tr[1]   <= reg_wdata & M_COLOR;
        AW'(OFF_TIMH):   tim_h   <= reg_wdata & M_TIMING;
        AW'(OFF_TIMV):   tim_v   <= reg_wdata & M_TIMING;
        AW'(OFF_POL):    pol     <= reg_wdata & M_POL;
        AW'(OFF_DIV):    div_w   <= reg_wdata & M_DIV;
        AW'(OFF_LCDSZ):  lcd_sz  <= reg_wdata & M_XY;
        AW'(OFF_DIGSZ):  dig_sz  <= reg_wdata & M_XY;
        AW'(OFF_GBASE):  g_base  <= reg_wdata;
        AW'(OFF_GPOS):   g_pos   <= reg_wdata & M_XY;
        AW'(OFF_GSIZE):  g_size  <= reg_wdata & M_XY;
        AW'(OFF_GATTR):  g_attr  <= reg_wdata & M_ATTR;
        AW'(OFF_ROWINC): row_inc <= reg_wdata;
        AW'(OFF_PIXINC): pix_inc <= reg_wdata;
        default: ;
      endcase
    end
  end

  assign lcd_en = ctrl_q[0];
  assign dig_en = ctrl_q[1];

  // go bits: index 0 = LCD, index 1 = digital
  logic [NUM_OUT-1:0] go_set, go_pend, go_xfer, frame_end;
  assign frame_end = {dig_frame_end, lcd_frame_end};

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_go
    assign go_set[i] = wr_en && at(reg_addr, OFF_CTRL) && reg_wdata[GO_BIT_LO + i];
    dispctl_go_track u_go (
      .clk(clk), .rst(srst), .set(go_set[i]), .frame_end(frame_end[i]),
      .pending(go_pend[i]), .xfer(go_xfer[i])
    );
  end

  // active banks
  logic [LCD_N-1:0][31:0] lcd_act;
  logic [GFX_N-1:0][31:0] gfx_act;
  logic [0:0][31:0]       dig_act;

  dispctl_shadow_bank #(.N(LCD_N), .W(32)) u_lcd_bank (
    .clk(clk), .rst(srst), .load(go_xfer[0]),
    .shadow({tim_h, tim_v, pol, div_w, lcd_sz}), .active(lcd_act)
  );
  dispctl_shadow_bank #(.N(GFX_N), .W(32)) u_gfx_bank (
    .clk(clk), .rst(srst), .load(|go_xfer),
    .shadow({g_base, g_pos, g_size, g_attr}), .active(gfx_act)
  );
  dispctl_shadow_bank #(.N(1), .W(32)) u_dig_bank (
    .clk(clk), .rst(srst), .load(go_xfer[1]),
    .shadow(dig_sz), .active(dig_act)
  );

  assign {act_timing_h, act_timing_v, act_pol_freq, act_divisor, act_lcd_size} = lcd_act;
  assign {act_gfx_base, act_gfx_pos, act_gfx_size, act_gfx_attr}             = gfx_act;
  assign act_dig_size = dig_act[0];

  // interrupt
  logic [IRQ_W-1:0] irq_st, irq_en;
  dispctl_irq #(.IRQ_W(IRQ_W)) u_irq (
    .clk(clk), .rst(srst),
    .en_we(wr_en && at(reg_addr, OFF_IRQEN)),
    .clr_we(wr_en && at(reg_addr, OFF_IRQST)),
    .wr_bits(reg_wdata[IRQ_W-1:0]), .event_bits(irq_event),
    .status(irq_st), .enable(irq_en), .irq(irq)
  );

  // read path
  word_t rd_mux;
  always_comb begin
    case (reg_addr)
      AW'(OFF_SYSCFG):  rd_mux = sys_cfg;
      AW'(OFF_SYSSTAT): rd_mux = 32'd1;
      AW'(OFF_IRQST):   rd_mux = word_t'(irq_st);
      AW'(OFF_IRQEN):   rd_mux = word_t'(irq_en);
      AW'(OFF_CTRL):    rd_mux = ctrl_q | (word_t'(go_pend) << GO_BIT_LO);
      AW'(OFF_CAPS):    rd_mux = caps;
      AW'(OFF_BG0):     rd_mux = bg[0];
      AW'(OFF_BG1):     rd_mux = bg[1];
      AW'(OFF_TR0):     rd_mux = tr[0];
      AW'(OFF_TR1):     rd_mux = tr[1];
      AW'(OFF_TIMH):    rd_mux = tim_h;
      AW'(OFF_TIMV):    rd_mux = tim_v;
      AW'(OFF_POL):     rd_mux = pol;
      AW'(OFF_DIV):     rd_mux = div_w;
      AW'(OFF_LCDSZ):   rd_mux = lcd_sz;
      AW'(OFF_DIGSZ):   rd_mux = dig_sz;
      AW'(OFF_GBASE):   rd_mux = g_base;
      AW'(OFF_GPOS):    rd_mux = g_pos;
      AW'(OFF_GSIZE):   rd_mux = g_size;
      AW'(OFF_GATTR):   rd_mux = g_attr;
      AW'(OFF_ROWINC):  rd_mux = row_inc;
      AW'(OFF_PIXINC):  rd_mux = pix_inc;
      default:          rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata  <= '0;
      reg_rvalid <= 1'b0;
    end else begin
      reg_rvalid <= rd_en;
      if (rd_en) reg_rdata <= rd_mux;
    end
  end

  // R2: read data is only flagged after a read request
  a_r2_rvalid_follows_read: assert property (@(posedge clk) disable iff (rst)
    reg_rvalid |-> $past(rd_en));
  // R7: the output enables move only on a control write or a reset
  a_r7_en_stable: assert property (@(posedge clk) disable iff (srst)
    !(wr_en && at(reg_addr, OFF_CTRL)) |=> ($stable(lcd_en) && $stable(dig_en)));
endmodule

// File: tb/dispctl_regs_tb_top.sv
module dispctl_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_valid = 1'b0, reg_write = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_rvalid;
  logic [15:0] irq_event = '0;
  logic        lcd_frame_end = 1'b0, dig_frame_end = 1'b0;
  logic        irq, lcd_en, dig_en;
  logic [31:0] act_timing_h, act_timing_v, act_pol_freq, act_divisor;
  logic [31:0] act_lcd_size, act_dig_size, act_gfx_base, act_gfx_pos;
  logic [31:0] act_gfx_size, act_gfx_attr;

  always #5 clk = ~clk;

  dispctl_regs #(.AW(8), .IRQ_W(16)) dut_i (
    .clk(clk), .rst(rst), .reg_valid(reg_valid), .reg_write(reg_write),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .irq_event(irq_event),
    .lcd_frame_end(lcd_frame_end), .dig_frame_end(dig_frame_end),
    .irq(irq), .lcd_en(lcd_en), .dig_en(dig_en),
    .act_timing_h(act_timing_h), .act_timing_v(act_timing_v),
    .act_pol_freq(act_pol_freq), .act_divisor(act_divisor),
    .act_lcd_size(act_lcd_size), .act_dig_size(act_dig_size),
    .act_gfx_base(act_gfx_base), .act_gfx_pos(act_gfx_pos),
    .act_gfx_size(act_gfx_size), .act_gfx_attr(act_gfx_attr)
  );

  typedef struct {
    logic [7:0]  addr;
    logic [31:0] exp;
    string       tag;
  } exp_item_t;

  exp_item_t sb_q[$];
  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: compares each returned read against the queue head
  always @(negedge clk) begin
    if (reg_rvalid === 1'b1) begin
      if (sb_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R2: unexpected read data actual=%h expected=none", reg_rdata);
      end else begin
        exp_item_t it;
        it = sb_q.pop_front();
        check(reg_rdata, it.exp, $sformatf("%s read @%h", it.tag, it.addr));
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    exp_item_t it;
    it.addr = a; it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
    @(negedge clk);
    reg_valid = 1'b0;
  endtask

  task automatic frame(input bit dig);
    @(negedge clk);
    if (dig) dig_frame_end = 1'b1; else lcd_frame_end = 1'b1;
    @(negedge clk);
    dig_frame_end = 1'b0; lcd_frame_end = 1'b0;
  endtask

  task automatic event_pulse(input logic [15:0] e);
    @(negedge clk);
    irq_event = e;
    @(negedge clk);
    irq_event = '0;
  endtask

  task automatic summary;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check({31'd0, irq}, 32'd0, "R1 irq");
    check({30'd0, dig_en, lcd_en}, 32'd0, "R1 enables");
    check(act_timing_h, 32'd0, "R1 act_timing_h");
    check(act_gfx_size, 32'd0, "R1 act_gfx_size");
    rd(8'h14, 32'h161, "R1 caps");
    rd(8'h50, 32'd1, "R1 row inc");
    rd(8'h54, 32'd1, "R1 pixel inc");
    rd(8'h04, 32'd1, "R1 sysstatus");
    rd(8'h48, 32'd0, "R1 gfx size");
    rd(8'h10, 32'd0, "R1 ctrl");

    // R2 unmapped read
    rd(8'h58, 32'd0, "R2 unmapped");
    rd(8'hFC, 32'd0, "R2 unmapped high");

    // R3 write masks, R7 enables
    wr(8'h10, 32'hFFFF_FF9F);
    check({30'd0, dig_en, lcd_en}, 32'd3, "R7 both enables");
    rd(8'h10, 32'h07FF_9F9F, "R3 ctrl mask");
    wr(8'h28, 32'hFFFF_FFFF);  rd(8'h28, 32'h0FF0_FF3F, "R3 timing h");
    wr(8'h2C, 32'hFFFF_FFFF);  rd(8'h2C, 32'h0FF0_FF3F, "R3 timing v");
    wr(8'h30, 32'hFFFF_FFFF);  rd(8'h30, 32'h0003_FFFF, "R3 pol");
    wr(8'h34, 32'hFFFF_FFFF);  rd(8'h34, 32'h00FF_00FF, "R3 divisor");
    wr(8'h18, 32'hFFFF_FFFF);  rd(8'h18, 32'h00FF_FFFF, "R3 bg0");
    wr(8'h24, 32'hABCD_EF12);  rd(8'h24, 32'h00CD_EF12, "R3 tr1");
    wr(8'h4C, 32'hFFFF_FFFF);  rd(8'h4C, 32'h0000_07FF, "R3 attr");
    wr(8'h14, 32'hFFFF_FFFF);  rd(8'h14, 32'h0000_03FF, "R3 caps");
    wr(8'h0C, 32'hFFFF_FFFF);  rd(8'h0C, 32'h0000_FFFF, "R3 irq enable");
    check({31'd0, irq}, 32'd0, "R6 no status no irq");
    wr(8'h10, 32'h0000_0002);
    check({30'd0, dig_en, lcd_en}, 32'd2, "R7 digital only");

    // R4 size encoding
    wr(8'h38, 32'hFFFF_FFFF);  rd(8'h38, 32'h07FF_07FF, "R4 lcd size mask");
    wr(8'h38, (32'd479 << 16) | 32'd639);
    rd(8'h38, 32'h01DF_027F, "R4 lcd size value");
    wr(8'h44, 32'h0123_0456);  rd(8'h44, 32'h0123_0456, "R4 gfx pos");

    // R5 / R6 interrupt
    wr(8'h0C, 32'h1);
    event_pulse(16'h0003);
    check({31'd0, irq}, 32'd1, "R6 irq on enabled status");
    rd(8'h08, 32'h3, "R5 status set");
    wr(8'h08, 32'h1);
    check({31'd0, irq}, 32'd0, "R6 irq after clear");
    rd(8'h08, 32'h2, "R5 w1c keeps others");
    wr(8'h0C, 32'h2);
    check({31'd0, irq}, 32'd1, "R6 irq after enable");
    wr(8'h08, 32'h2);
    check({31'd0, irq}, 32'd0, "R6 irq cleared");
    event_pulse(16'h0004);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b1; reg_addr = 8'h08; reg_wdata = 32'h4;
    irq_event = 16'h0004;
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0; irq_event = '0;
    rd(8'h08, 32'h4, "R5 set wins over clear");
    wr(8'h0C, 32'hFFFF);
    check({31'd0, irq}, 32'd1, "R6 irq from enable write");

    // R8 LCD go and R10 hold
    wr(8'h40, 32'hDEAD_BEEF);
    check(act_timing_h, 32'd0, "R10 act timing before go");
    check(act_gfx_base, 32'd0, "R10 act base before go");
    wr(8'h10, 32'h21);
    rd(8'h10, 32'h21, "R8 go pending reads 1");
    check(act_timing_h, 32'd0, "R10 no transfer without frame");
    wr(8'h10, 32'h01);
    rd(8'h10, 32'h21, "R8 go not cancelled");
    frame(1'b1);
    check(act_timing_h, 32'd0, "R10 wrong frame pulse");
    frame(1'b0);
    check(act_timing_h, 32'h0FF0_FF3F, "R8 act timing h");
    check(act_lcd_size, 32'h01DF_027F, "R8 act lcd size");
    check(act_gfx_base, 32'hDEAD_BEEF, "R8 act gfx base");
    check(act_gfx_pos, 32'h0123_0456, "R8 act gfx pos");
    check(act_dig_size, 32'd0, "R10 dig size untouched");
    rd(8'h10, 32'h01, "R8 go self-clears");

    // R9 digital go
    wr(8'h3C, 32'h0010_0020);
    wr(8'h40, 32'h1234_5678);
    wr(8'h10, 32'h41);
    rd(8'h10, 32'h41, "R9 dig go pending");
    frame(1'b0);
    check(act_gfx_base, 32'hDEAD_BEEF, "R10 lcd pulse without go");
    check(act_dig_size, 32'd0, "R10 dig size held");
    frame(1'b1);
    check(act_dig_size, 32'h0010_0020, "R9 act dig size");
    check(act_gfx_base, 32'h1234_5678, "R9 act gfx base");
    check(act_gfx_attr, 32'h0000_07FF, "R9 act gfx attr");
    check(act_timing_h, 32'h0FF0_FF3F, "R9 lcd fields kept");
    rd(8'h10, 32'h01, "R9 dig go self-clears");

    // R12 ignored writes
    wr(8'h58, 32'hFFFF_FFFF);
    wr(8'h04, 32'h0);
    rd(8'h10, 32'h01, "R12 ctrl unchanged");
    rd(8'h14, 32'h3FF, "R12 caps unchanged");
    rd(8'h58, 32'd0, "R12 unmapped still 0");
    rd(8'h04, 32'd1, "R12 sysstatus still 1");
    check({30'd0, dig_en, lcd_en}, 32'd1, "R12 enables unchanged");
    check(act_gfx_base, 32'h1234_5678, "R12 active unchanged");

    // R11 soft reset
    wr(8'h00, 32'hFFFF_FFFF);
    check({31'd0, irq}, 32'd0, "R11 irq");
    check({30'd0, dig_en, lcd_en}, 32'd0, "R11 enables");
    check(act_timing_h, 32'd0, "R11 act timing");
    check(act_dig_size, 32'd0, "R11 act dig size");
    rd(8'h00, 32'h0000_301B, "R11 sysconfig kept");
    rd(8'h14, 32'h161, "R11 caps");
    rd(8'h10, 32'd0, "R11 ctrl");
    rd(8'h0C, 32'd0, "R11 irq enable");
    rd(8'h08, 32'd0, "R11 status");
    rd(8'h50, 32'd1, "R11 row inc");
    rd(8'h28, 32'd0, "R11 timing h");

    repeat (3) @(negedge clk);
    if (sb_q.size() != 0) begin
      n_chk++; n_bad++;
      $display("FAIL R2: missing reads actual=%0d expected=0", sb_q.size());
    end
    finished = 1;
    summary();
    $finish;
  end
endmodule